// File: doc/BRIEF.md
# Data-Enable Display Timing Generator

This block produces the raster timing for a 1366 x 768 panel that recognises line and frame boundaries only from gaps in the data-enable signal. A horizontal counter and a vertical counter step on every pixel clock. Each line starts with its active pixels, and each frame starts with its active lines. The rest of the line or frame is blanking. The block presents the data-enable strobe, the current pixel column and line number, and a one-clock start-of-frame marker.

Software supplies the horizontal and vertical totals. The block forces any value outside the legal window to the nearest limit. A new value is only taken at a frame boundary, so no frame ever has a mix of old and new geometry. Together, the two totals set the refresh rate: the legal windows cover the 48 to 52 Hz and 58 to 62 Hz bands at the panel's pixel rate.

A pixel request output runs a fixed number of clocks ahead of data-enable, so that an upstream source with that latency places valid pixels exactly in the enabled clocks. The data bus is treated as invalid whenever data-enable is low. Optional horizontal and vertical sync strobes, which the panel does not need, can be generated into the blanking intervals.

Top module: `dtg_de_timing`

## Requirements
- R1: While reset is asserted, `de`, `pix_req`, `sof`, `hsync` and `vsync` are 0, and `hpos` and `vpos` are 0.
- R2: Every line that contains active pixels has exactly H_ACTIVE consecutive clocks with `de` high, starting at the first clock of the line. During those clocks `hpos` counts 0, 1, ... H_ACTIVE-1.
- R3: Every frame contains exactly V_ACTIVE lines with `de` activity. These are the first lines of the frame, and `vpos` equals 0 ... V_ACTIVE-1 during them.
- R4: A frame lasts exactly H_TOTAL x V_TOTAL clocks, measured from one `sof` to the next, using the clamped totals.
- R5: A horizontal total below H_MIN is used as H_MIN, a total above H_MAX is used as H_MAX, and values in between are used unchanged.
- R6: A vertical total below V_MIN is used as V_MIN, a total above V_MAX is used as V_MAX, and values in between are used unchanged.
- R7: The totals present on the inputs at the clock edge that begins a frame govern that whole frame. A change in the middle of a frame has no effect on that frame's length.
- R8: `sof` is high for exactly one clock per frame, in the clock where `de` is first high with `hpos` = 0 and `vpos` = 0.
- R9: `pix_req` equals `de` shifted earlier by exactly REQ_LEAD clocks. REQ_LEAD = 0 makes the two identical.
- R10: With syncs enabled, `hsync` is high for HS_WIDTH clocks in every line and `vsync` is high for VS_WIDTH whole lines in every frame. Both lie entirely in blanking and never overlap `de`.
- R11: The horizontal position keeps counting through blanking and wraps to 0 after H_TOTAL-1. The line number advances at each wrap, so consecutive `de` rising edges within a frame are exactly H_TOTAL clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| htotal_cfg | input | HW | Requested clocks per line |
| vtotal_cfg | input | VW | Requested lines per frame |
| pix_req | output | 1 | Pixel request, REQ_LEAD clocks ahead of `de` |
| de | output | 1 | Data enable; pixel bus valid only while high |
| hpos | output | HW | Pixel column within the line |
| vpos | output | VW | Line number within the frame |
| sof | output | 1 | One-clock start-of-frame marker |
| hsync | output | 1 | Optional horizontal sync strobe in blanking |
| vsync | output | 1 | Optional vertical sync strobe in blanking |

## Verification
The embedded properties assume that the parameters satisfy the elaboration checks: each minimum total exceeds its active count, and each sync width fits inside the shortest blanking. Under those conditions, any total input, legal or not, keeps every counter below its registered total. The stimulus uses a scaled-down raster with the same structure as the panel geometry, so whole frames fit in a short run. It drives totals at, below and above both limits, and changes them only away from the frame edge, except for the deliberate mid-frame change, which tests the frame-boundary rule. Frames are measured only after one full frame has passed since the last change, so every measured frame runs on a single pair of totals.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

   // Per-clock raster flags carried together through the output delay line.
   typedef struct packed {
      logic de;
      logic sof;
      logic hs;
      logic vs;
   } dtg_flags_t;

   // Bits needed to hold a total up to max_total (inclusive).
   function automatic int unsigned dtg_cnt_width(input int unsigned max_total);
      return (max_total < 2) ? 1 : $clog2(max_total + 1);
   endfunction

endpackage

// File: rtl/dtg_total_clamp.sv
module dtg_total_clamp #(
   parameter int unsigned W  = 11,
   parameter int unsigned LO = 1400,
   parameter int unsigned HI = 2000
) (
   input  logic [W-1:0] raw,
   output logic [W-1:0] legal
);

   localparam logic [W-1:0] LO_L = W'(LO);
   localparam logic [W-1:0] HI_L = W'(HI);

   if (LO > HI) begin : g_bad_window
      $error("dtg_total_clamp: LO must not exceed HI");
   end
   if (HI >= (1 << W)) begin : g_bad_width
      $error("dtg_total_clamp: HI does not fit in W bits");
   end

   always_comb begin
      if (raw < LO_L)      legal = LO_L;
      else if (raw > HI_L) legal = HI_L;
      else                 legal = raw;
   end

endmodule

// File: rtl/dtg_axis_counter.sv
module dtg_axis_counter #(
   parameter int unsigned W       = 11,
   parameter int unsigned ACTIVE  = 1366,
   parameter int unsigned MIN_TOT = 1400,
   parameter int unsigned MAX_TOT = 2000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         load,
   input  logic [W-1:0] total_in,
   output logic [W-1:0] cnt,
   output logic         last,
   output logic         in_active
);

   localparam logic [W-1:0] ACT_L = W'(ACTIVE);
   localparam logic [W-1:0] MIN_L = W'(MIN_TOT);
   localparam logic [W-1:0] MAX_L = W'(MAX_TOT);
   localparam logic [W-1:0] ONE_L = W'(1);

   if (MIN_TOT <= ACTIVE) begin : g_bad_blank
      $error("dtg_axis_counter: minimum total must exceed active count");
   end

   logic [W-1:0] total_q;
   logic [W-1:0] cnt_q;

   assign last      = (cnt_q == (total_q - ONE_L));
   assign in_active = (cnt_q < ACT_L);
   assign cnt       = cnt_q;

   // Shadowed total: only replaced on a load strobe (frame boundary).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total_q <= MAX_L;
      end else if (load) begin
         total_q <= total_in;
      end
   end

   // Position counter; wraps after total-1 using the total in force.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= last ? '0 : (cnt_q + ONE_L);
      end
   end

   // R11: position never reaches the total that bounds it
   a_r11_cnt_below_total: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < total_q);

   // R5 / R6: the total in force always lies in the legal window
   a_r5_r6_total_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (total_q >= MIN_L) && (total_q <= MAX_L));

   // R7: the total only moves on a frame-boundary load
   a_r7_total_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(total_q));

endmodule

// File: rtl/dtg_de_timing.sv
module dtg_de_timing #(
   parameter int unsigned H_ACTIVE = 1366,
   parameter int unsigned V_ACTIVE = 768,
   parameter int unsigned H_MIN    = 1400,
   parameter int unsigned H_MAX    = 2000,
   parameter int unsigned V_MIN    = 773,
   parameter int unsigned V_MAX    = 1000,
   parameter int unsigned REQ_LEAD = 2,
   parameter bit          SYNC_EN  = 1'b1,
   parameter int unsigned HS_WIDTH = 16,
   parameter int unsigned VS_WIDTH = 2,
   localparam int unsigned HW = dtg_pkg::dtg_cnt_width(H_MAX),
   localparam int unsigned VW = dtg_pkg::dtg_cnt_width(V_MAX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [HW-1:0] htotal_cfg,
   input  logic [VW-1:0] vtotal_cfg,
   output logic          pix_req,
   output logic          de,
   output logic [HW-1:0] hpos,
   output logic [VW-1:0] vpos,
   output logic          sof,
   output logic          hsync,
   output logic          vsync
);

   import dtg_pkg::*;

   // ---------------- elaboration checks ----------------
   if (H_MIN <= H_ACTIVE) begin : g_chk_hblank
      $error("dtg_de_timing: H_MIN must exceed H_ACTIVE");
   end
   if (V_MIN <= V_ACTIVE) begin : g_chk_vblank
      $error("dtg_de_timing: V_MIN must exceed V_ACTIVE");
   end
   if (SYNC_EN && (HS_WIDTH > H_MIN - H_ACTIVE)) begin : g_chk_hs
      $error("dtg_de_timing: HS_WIDTH exceeds shortest horizontal blanking");
   end
   if (SYNC_EN && (VS_WIDTH > V_MIN - V_ACTIVE)) begin : g_chk_vs
      $error("dtg_de_timing: VS_WIDTH exceeds shortest vertical blanking");
   end
   if (REQ_LEAD > 16) begin : g_chk_lead
      $error("dtg_de_timing: REQ_LEAD limited to 16");
   end

   // ---------------- totals: clamp then shadow ----------------
   logic [HW-1:0] htot_legal;
   logic [VW-1:0] vtot_legal;

   dtg_total_clamp #(.W(HW), .LO(H_MIN), .HI(H_MAX)) u_hclamp (
      .raw   (htotal_cfg),
      .legal (htot_legal)
   );

   dtg_total_clamp #(.W(VW), .LO(V_MIN), .HI(V_MAX)) u_vclamp (
      .raw   (vtotal_cfg),
      .legal (vtot_legal)
   );

   // ---------------- raster counters ----------------
   logic          primed;
   logic          frame_load;
   logic [HW-1:0] h_cnt;
   logic [VW-1:0] v_cnt;
   logic          h_last, v_last, h_act, v_act;

   // One idle cycle after reset so the first frame loads real totals.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   assign frame_load = !primed || (h_last && v_last);

   dtg_axis_counter #(.W(HW), .ACTIVE(H_ACTIVE), .MIN_TOT(H_MIN), .MAX_TOT(H_MAX)) u_hcnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (primed),
      .load      (frame_load),
      .total_in  (htot_legal),
      .cnt       (h_cnt),
      .last      (h_last),
      .in_active (h_act)
   );

   dtg_axis_counter #(.W(VW), .ACTIVE(V_ACTIVE), .MIN_TOT(V_MIN), .MAX_TOT(V_MAX)) u_vcnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (primed && h_last),
      .load      (frame_load),
      .total_in  (vtot_legal),
      .cnt       (v_cnt),
      .last      (v_last),
      .in_active (v_act)
   );

   // ---------------- raw flags ----------------
   dtg_flags_t raw_f;
   logic       raw_hs, raw_vs;

   if (SYNC_EN) begin : g_sync
      localparam logic [HW-1:0] HS_BEG = HW'(H_ACTIVE);
      localparam logic [HW-1:0] HS_END = HW'(H_ACTIVE + HS_WIDTH);
      localparam logic [VW-1:0] VS_BEG = VW'(V_ACTIVE);
      localparam logic [VW-1:0] VS_END = VW'(V_ACTIVE + VS_WIDTH);
      assign raw_hs = primed && (h_cnt >= HS_BEG) && (h_cnt < HS_END);
      assign raw_vs = primed && (v_cnt >= VS_BEG) && (v_cnt < VS_END);
   end else begin : g_nosync
      assign raw_hs = 1'b0;
      assign raw_vs = 1'b0;
   end

   always_comb begin
      raw_f.de  = primed && h_act && v_act;
      raw_f.sof = primed && (h_cnt == '0) && (v_cnt == '0);
      raw_f.hs  = raw_hs;
      raw_f.vs  = raw_vs;
   end

   // ---------------- stage 0: request point ----------------
   dtg_flags_t    s0_f;
   logic [HW-1:0] s0_h;
   logic [VW-1:0] s0_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s0_f <= '0;
         s0_h <= '0;
         s0_v <= '0;
      end else begin
         s0_f <= raw_f;
         s0_h <= h_cnt;
         s0_v <= v_cnt;
      end
   end

   assign pix_req = s0_f.de;

   // ---------------- output delay line ----------------
   dtg_flags_t    out_f;
   logic [HW-1:0] out_h;
   logic [VW-1:0] out_v;

   if (REQ_LEAD == 0) begin : g_nolead
      assign out_f = s0_f;
      assign out_h = s0_h;
      assign out_v = s0_v;
   end else begin : g_lead
      dtg_flags_t    dl_f [REQ_LEAD];
      logic [HW-1:0] dl_h [REQ_LEAD];
      logic [VW-1:0] dl_v [REQ_LEAD];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < REQ_LEAD; i++) begin
               dl_f[i] <= '0;
               dl_h[i] <= '0;
               dl_v[i] <= '0;
            end
         end else begin
            dl_f[0] <= s0_f;
            dl_h[0] <= s0_h;
            dl_v[0] <= s0_v;
            for (int i = 1; i < REQ_LEAD; i++) begin
               dl_f[i] <= dl_f[i-1];
               dl_h[i] <= dl_h[i-1];
               dl_v[i] <= dl_v[i-1];
            end
         end
      end

      assign out_f = dl_f[REQ_LEAD-1];
      assign out_h = dl_h[REQ_LEAD-1];
      assign out_v = dl_v[REQ_LEAD-1];
   end

   assign de    = out_f.de;
   assign sof   = out_f.sof;
   assign hsync = out_f.hs;
   assign vsync = out_f.vs;
   assign hpos  = out_h;
   assign vpos  = out_v;

   // ---------------- properties on the outputs ----------------
   // R8: frame marker sits on the first enabled pixel of line 0
   a_r8_sof_on_origin: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> (de && (hpos == '0) && (vpos == '0)));

   // R8: frame marker lasts a single clock
   a_r8_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> !sof);

   // R2: column steps by one inside an enabled run
   a_r2_hpos_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (de && (hpos != '0)) |-> (hpos == HW'($past(hpos) + 1'b1)));

   // R3: enable only appears on active line numbers
   a_r3_de_line_range: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (vpos < VW'(V_ACTIVE)));

   // R10: sync strobes never overlap enabled pixels
   a_r10_sync_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync || vsync) |-> !de);

endmodule

// File: tb/dtg_de_timing_bench.sv
`timescale 1ns/1ps
module dtg_de_timing_bench;

   localparam int HA   = 16;
   localparam int VA   = 5;
   localparam int HMIN = 20;
   localparam int HMAX = 28;
   localparam int VMIN = 7;
   localparam int VMAX = 10;
   localparam int LEAD = 2;
   localparam int HSW  = 2;
   localparam int VSW  = 1;
   localparam int HW   = $clog2(HMAX + 1);
   localparam int VW   = $clog2(VMAX + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [HW-1:0] htotal_cfg = HW'(24);
   logic [VW-1:0] vtotal_cfg = VW'(8);
   logic          pix_req, de, sof, hsync, vsync;
   logic [HW-1:0] hpos;
   logic [VW-1:0] vpos;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   dtg_de_timing #(
      .H_ACTIVE(HA), .V_ACTIVE(VA), .H_MIN(HMIN), .H_MAX(HMAX),
      .V_MIN(VMIN), .V_MAX(VMAX), .REQ_LEAD(LEAD), .SYNC_EN(1'b1),
      .HS_WIDTH(HSW), .VS_WIDTH(VSW)
   ) u_dtg_de_timing (
      .clk(clk), .rst_n(rst_n), .htotal_cfg(htotal_cfg), .vtotal_cfg(vtotal_cfg),
      .pix_req(pix_req), .de(de), .hpos(hpos), .vpos(vpos), .sof(sof),
      .hsync(hsync), .vsync(vsync)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int clampi(input int v, input int lo, input int hi);
      return (v < lo) ? lo : ((v > hi) ? hi : v);
   endfunction

   // Request-vs-enable monitor (R9)
   logic [7:0] req_hist = '0;
   int req_err = 0;
   int req_seen = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         req_hist = '0;
      end else begin
         if (req_hist[LEAD-1] !== de) req_err++;
         if (pix_req) req_seen++;
         req_hist = {req_hist[6:0], pix_req};
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // Measures one frame from a sof to the next, sampled at negedges.
   task automatic capture_frame(input int exp_h,
                                output int clk_cnt, output int lines, output int de_total,
                                output int line_err, output int order_err, output int period_err,
                                output int hs_cnt, output int vs_cnt, output int overlap,
                                output int sof_err);
      int run, last_rise;
      bit prev_de, first_rise;
      clk_cnt = 0; lines = 0; de_total = 0; line_err = 0; order_err = 0;
      period_err = 0; hs_cnt = 0; vs_cnt = 0; overlap = 0; sof_err = 0;
      run = 0; last_rise = 0; prev_de = 1'b0; first_rise = 1'b1;
      while (!sof) @(negedge clk);
      if (!(de && hpos == 0 && vpos == 0)) sof_err++;
      do begin
         if (de) begin
            if (!prev_de) begin
               if (!first_rise && (clk_cnt - last_rise != exp_h)) period_err++;
               first_rise = 1'b0;
               last_rise = clk_cnt;
            end
            if (int'(hpos) != run) order_err++;
            if (int'(vpos) != lines) order_err++;
            run++;
            de_total++;
         end else if (prev_de) begin
            if (run != HA) line_err++;
            lines++;
            run = 0;
         end
         if (hsync) hs_cnt++;
         if (vsync) vs_cnt++;
         if ((hsync || vsync) && de) overlap++;
         prev_de = de;
         @(negedge clk);
         clk_cnt++;
      end while (!sof);
   endtask

   // Apply totals, let one frame boundary pass, then measure a clean frame.
   task automatic t_frame(input string tag, input int h_in, input int v_in);
      int eh, ev, fc, ln, dt, le, oe, pe, hc, vc, ov, se;
      eh = clampi(h_in, HMIN, HMAX);
      ev = clampi(v_in, VMIN, VMAX);
      @(negedge clk);
      htotal_cfg = HW'(h_in);
      vtotal_cfg = VW'(v_in);
      while (!sof) @(negedge clk);
      @(negedge clk);
      capture_frame(eh, fc, ln, dt, le, oe, pe, hc, vc, ov, se);
      $display("  scenario %s: h=%0d v=%0d frame=%0d", tag, h_in, v_in, fc);
      chk("R4 R5 R6", {tag, " frame clocks"}, fc, eh * ev);
      chk("R3", {tag, " active lines"}, ln, VA);
      chk("R2", {tag, " enabled clocks"}, dt, HA * VA);
      chk("R2", {tag, " short or long lines"}, le, 0);
      chk("R2 R3", {tag, " position order errors"}, oe, 0);
      chk("R11", {tag, " line period errors"}, pe, 0);
      chk("R8", {tag, " sof placement errors"}, se, 0);
      chk("R10", {tag, " hsync clocks"}, hc, ev * HSW);
      chk("R10", {tag, " vsync clocks"}, vc, VSW * eh);
      chk("R10", {tag, " sync over de"}, ov, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "de in reset", int'(de), 0);
      chk("R1", "pix_req in reset", int'(pix_req), 0);
      chk("R1", "sof in reset", int'(sof), 0);
      chk("R1", "syncs in reset", int'(hsync) + int'(vsync), 0);
      chk("R1", "positions in reset", int'(hpos) + int'(vpos), 0);
      rst_n = 1'b1;
   endtask

   // Mid-frame change must not alter the frame in progress (R7).
   task automatic t_midframe();
      int fc, ln, dt, le, oe, pe, hc, vc, ov, se, n;
      @(negedge clk);
      htotal_cfg = HW'(24);
      vtotal_cfg = VW'(8);
      while (!sof) @(negedge clk);
      @(negedge clk);
      while (!sof) @(negedge clk);
      n = 0;
      do begin
         if (n == 30) begin
            htotal_cfg = HW'(20);
            vtotal_cfg = VW'(7);
         end
         @(negedge clk);
         n++;
      end while (!sof);
      chk("R7", "frame with mid-frame change", n, 24 * 8);
      capture_frame(20, fc, ln, dt, le, oe, pe, hc, vc, ov, se);
      chk("R7", "following frame uses new totals", fc, 20 * 7);
   endtask

   task automatic t_request();
      chk("R9", "pix_req vs delayed de mismatches", req_err, 0);
      chk("R9", "pix_req activity seen", int'(req_seen > 0), 1);
   endtask

   initial begin
      t_reset();
      t_frame("nominal", 24, 8);
      t_frame("minimum", HMIN, VMIN);
      t_frame("maximum", HMAX, VMAX);
      t_frame("below", 5, 2);
      t_frame("above", 31, 15);
      t_frame("mixed", 22, 9);
      t_midframe();
      t_request();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule